// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the outbound path from a host bus towards a serial link and rewrites each outgoing 64-bit address. It holds eight programmable windows. Every window has four parts: a match value whose bit 0 is the enable, a remap value, a mask, and a 32-bit action word. The action word tells the link side which transaction type and which attributes to use. An address that falls inside an enabled window has its high bits replaced from that window's remap value and takes that window's action word. An address that falls inside no window passes through unchanged and takes a separate default action word. This gives transparent memory access when no windows are programmed.

Addresses arrive on a valid/ready stream and leave on a second valid/ready stream, one register stage later. The input is accepted on any cycle in which the output register is empty or is being drained. When the consumer holds `out_ready` low, the result already in the register stays on the outputs and `in_ready` drops, so back-pressure reaches the producer in the same cycle. Software programs the windows through a plain word-wide write/read port. Reads of that port are combinational.

Top module: `obwin_xlate`

## Requirements
- R1: After reset, every register reads zero. Every window is therefore disabled, and the default action selects memory type. `out_valid` is 0 and `in_ready` is 1.
- R2: Window n's registers lie at 0x4C00 + 0x20*n, at these offsets: match low word +0x00, match high +0x04, remap low +0x08, remap high +0x0C, mask low +0x10, mask high +0x14, action +0x18. The default action lies at 0x4CFC. Each of these reads back the value last written. Writes to any other address, including +0x1C of windows 0 to 6, change nothing, and reads of such addresses return 0.
- R3: A window hits only when bit 0 of its match low word is 1 and the address equals the match value in every bit where the mask is 1. Mask bits 15:0 are always treated as 0, so the smallest window is 64 KiB.
- R4: On a hit, `out_addr` = (remap AND m) OR (in_addr AND NOT m), where m is the mask with bits 15:0 cleared. Address bits 15:0 always pass unchanged.
- R5: On a miss, `out_addr` equals `in_addr`, `out_action` equals the default action, `out_hit` is 0 and `out_win` is 0.
- R6: When several windows hit, the lowest-numbered one supplies the address, the action and `out_win`.
- R7: A window whose seven registers have all been written with zero never hits, whatever the address.
- R8: On a hit, `out_action` is the window's action word, passed bit for bit. Bits 3:0 are the type field (0x0 memory, 0x4 I/O, 0x8 type-0 configuration, 0x9 type-1 configuration, 0xC message). Bit 4 is ID-based ordering, bit 5 poison, bit 6 no-snoop, bit 7 relaxed ordering, bits 10:8 traffic class and bit 11 attribute enable. `out_kind_err` is 1 exactly when the type field of the selected action holds none of the five codes.
- R9: An address accepted on a clock edge (`in_valid` and `in_ready` both high) appears on the outputs with `out_valid` = 1 after that edge. `in_ready` is high when `out_valid` is 0 or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, every output stays unchanged.
- R10: A translation uses the register values in place before the edge that accepts the address. A register write on that same edge affects only later addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input address valid |
| in_ready | output | 1 | Block can accept an address |
| in_addr | input | 64 | Host-side address |
| out_valid | output | 1 | Translated result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_addr | output | 64 | Link-side address |
| out_action | output | 32 | Selected action word |
| out_hit | output | 1 | 1 when a window supplied the result |
| out_win | output | 3 | Index of the hitting window, 0 on a miss |
| out_kind_err | output | 1 | Type field of the selected action holds an unknown code |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 16 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |

## Verification
The assertions assume that `in_addr` and the configuration inputs carry known values whenever reset is released. They also assume that register addresses are word aligned; an unaligned address is simply left undecoded. The stall properties are written against the output register itself, so they hold no matter how the producer behaves. Even so, the stimulus follows stream rules: it changes `in_addr` only after it has seen an address accepted, and it holds one address steady through a stall. Every configuration address the stimulus uses is word aligned, and the reserved and out-of-range addresses it touches are among them.

// File: rtl/obwin_pkg.sv
package obwin_pkg;

  localparam int unsigned ADDR_W    = 64;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned CFG_AW    = 16;
  localparam int unsigned GRAN_BITS = 16;
  localparam int unsigned BLK_BITS  = 5;

  // Word offsets inside one window block (software decodes these).
  localparam logic [BLK_BITS-1:0] OFF_MATCH_LO = 5'h00;
  localparam logic [BLK_BITS-1:0] OFF_MATCH_HI = 5'h04;
  localparam logic [BLK_BITS-1:0] OFF_REMAP_LO = 5'h08;
  localparam logic [BLK_BITS-1:0] OFF_REMAP_HI = 5'h0C;
  localparam logic [BLK_BITS-1:0] OFF_MASK_LO  = 5'h10;
  localparam logic [BLK_BITS-1:0] OFF_MASK_HI  = 5'h14;
  localparam logic [BLK_BITS-1:0] OFF_ACTION   = 5'h18;
  localparam logic [BLK_BITS-1:0] OFF_DEFAULT  = 5'h1C;

  // Mask bits that may take part in a compare: the low granule never does.
  localparam logic [ADDR_W-1:0] KEEP_MASK =
    {{(ADDR_W-GRAN_BITS){1'b1}}, {GRAN_BITS{1'b0}}};

  typedef enum logic [3:0] {
    KIND_MEM  = 4'h0,
    KIND_IO   = 4'h4,
    KIND_CFG0 = 4'h8,
    KIND_CFG1 = 4'h9,
    KIND_MSG  = 4'hC
  } kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] match;
    logic [ADDR_W-1:0] remap;
    logic [ADDR_W-1:0] mask;
    logic [WORD_W-1:0] action;
  } win_cfg_t;

  function automatic logic kind_known(input logic [3:0] k);
    case (k)
      KIND_MEM, KIND_IO, KIND_CFG0, KIND_CFG1, KIND_MSG: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
  import obwin_pkg::*;
#(
  parameter int unsigned       NWIN = 8,
  parameter logic [CFG_AW-1:0] BASE = 16'h4C00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output win_cfg_t          wcfg [NWIN],
  output logic [WORD_W-1:0] dflt_action,
  output logic [WORD_W-1:0] cfg_rdata
);

  localparam int unsigned IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int unsigned SPAN  = NWIN << BLK_BITS;

  logic [CFG_AW-1:0]   rel;
  logic                in_span;
  logic [IDX_W-1:0]    idx;
  logic [BLK_BITS-1:0] off;
  logic                dflt_sel;
  logic [WORD_W-1:0]   dflt_q;

  assign rel      = cfg_addr - BASE;
  assign in_span  = (cfg_addr >= BASE) && (32'(rel) < SPAN);
  assign idx      = rel[BLK_BITS +: IDX_W];
  assign off      = rel[BLK_BITS-1:0];
  assign dflt_sel = in_span && (idx == IDX_W'(NWIN-1)) && (off == OFF_DEFAULT);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic              sel;
    logic [ADDR_W-1:0] m_q, r_q, k_q;
    logic [WORD_W-1:0] a_q;

    assign sel = cfg_we && in_span && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= '0;
        r_q <= '0;
        k_q <= '0;
        a_q <= '0;
      end else if (sel) begin
        case (off)
          OFF_MATCH_LO: m_q[WORD_W-1:0]      <= cfg_wdata;
          OFF_MATCH_HI: m_q[ADDR_W-1:WORD_W] <= cfg_wdata;
          OFF_REMAP_LO: r_q[WORD_W-1:0]      <= cfg_wdata;
          OFF_REMAP_HI: r_q[ADDR_W-1:WORD_W] <= cfg_wdata;
          OFF_MASK_LO:  k_q[WORD_W-1:0]      <= cfg_wdata;
          OFF_MASK_HI:  k_q[ADDR_W-1:WORD_W] <= cfg_wdata;
          OFF_ACTION:   a_q                  <= cfg_wdata;
          default: ;
        endcase
      end
    end

    assign wcfg[g] = '{match: m_q, remap: r_q, mask: k_q, action: a_q};

    AST_WIN_DISABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sel && (off == OFF_MATCH_LO) && !cfg_wdata[0] |=> !wcfg[g].match[0]); // R7
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dflt_q <= '0;
    else if (cfg_we && dflt_sel) dflt_q <= cfg_wdata;
  end

  assign dflt_action = dflt_q;

  always_comb begin
    cfg_rdata = '0;
    if (dflt_sel) begin
      cfg_rdata = dflt_q;
    end else if (in_span) begin
      case (off)
        OFF_MATCH_LO: cfg_rdata = wcfg[idx].match[WORD_W-1:0];
        OFF_MATCH_HI: cfg_rdata = wcfg[idx].match[ADDR_W-1:WORD_W];
        OFF_REMAP_LO: cfg_rdata = wcfg[idx].remap[WORD_W-1:0];
        OFF_REMAP_HI: cfg_rdata = wcfg[idx].remap[ADDR_W-1:WORD_W];
        OFF_MASK_LO:  cfg_rdata = wcfg[idx].mask[WORD_W-1:0];
        OFF_MASK_HI:  cfg_rdata = wcfg[idx].mask[ADDR_W-1:WORD_W];
        OFF_ACTION:   cfg_rdata = wcfg[idx].action;
        default:      cfg_rdata = '0;
      endcase
    end
  end

  AST_DFLT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && dflt_sel |=> dflt_action == $past(cfg_wdata)); // R2

endmodule

// File: rtl/obwin_cmp.sv
module obwin_cmp
  import obwin_pkg::*;
(
  input  logic [ADDR_W-1:0] match,
  input  logic [ADDR_W-1:0] remap,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr
);

  logic [ADDR_W-1:0] eff_mask;

  assign eff_mask = mask & KEEP_MASK;
  assign hit      = match[0] && (((addr ^ match) & eff_mask) == '0);
  assign xaddr    = (remap & eff_mask) | (addr & ~eff_mask);

endmodule

// File: rtl/obwin_pick.sv
module obwin_pick
  import obwin_pkg::*;
#(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [NWIN-1:0]   hit,
  input  logic [ADDR_W-1:0] xaddr  [NWIN],
  input  logic [WORD_W-1:0] action [NWIN],
  input  logic [WORD_W-1:0] dflt_action,
  input  logic [ADDR_W-1:0] addr,
  output logic              any,
  output logic [IDX_W-1:0]  win,
  output logic [ADDR_W-1:0] paddr,
  output logic [WORD_W-1:0] pact,
  output logic [NWIN-1:0]   grant
);

  // Scan from the top down so the lowest hitting index is written last.
  always_comb begin
    any   = 1'b0;
    win   = '0;
    paddr = addr;
    pact  = dflt_action;
    grant = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any      = 1'b1;
        win      = IDX_W'(i);
        paddr    = xaddr[i];
        pact     = action[i];
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
#(
  parameter int unsigned       NWIN     = 8,
  parameter logic [CFG_AW-1:0] CFG_BASE = 16'h4C00,
  localparam int unsigned      WIN_W    = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [WORD_W-1:0] out_action,
  output logic              out_hit,
  output logic [WIN_W-1:0]  out_win,
  output logic              out_kind_err,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata
);

  win_cfg_t          wcfg     [NWIN];
  logic [ADDR_W-1:0] xaddr    [NWIN];
  logic [WORD_W-1:0] act_arr  [NWIN];
  logic [NWIN-1:0]   hit_vec;
  logic [NWIN-1:0]   grant;
  logic [WORD_W-1:0] dflt_action;
  logic              any;
  logic [WIN_W-1:0]  pwin;
  logic [ADDR_W-1:0] paddr;
  logic [WORD_W-1:0] pact;
  logic              fire;

  obwin_regs #(.NWIN(NWIN), .BASE(CFG_BASE)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .wcfg        (wcfg),
    .dflt_action (dflt_action),
    .cfg_rdata   (cfg_rdata)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    obwin_cmp u_cmp (
      .match (wcfg[g].match),
      .remap (wcfg[g].remap),
      .mask  (wcfg[g].mask),
      .addr  (in_addr),
      .hit   (hit_vec[g]),
      .xaddr (xaddr[g])
    );
    assign act_arr[g] = wcfg[g].action;
  end

  obwin_pick #(.NWIN(NWIN), .IDX_W(WIN_W)) u_pick (
    .hit         (hit_vec),
    .xaddr       (xaddr),
    .action      (act_arr),
    .dflt_action (dflt_action),
    .addr        (in_addr),
    .any         (any),
    .win         (pwin),
    .paddr       (paddr),
    .pact        (pact),
    .grant       (grant)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_action   <= '0;
      out_hit      <= 1'b0;
      out_win      <= '0;
      out_kind_err <= 1'b0;
    end else if (fire) begin
      out_valid    <= 1'b1;
      out_addr     <= paddr;
      out_action   <= pact;
      out_hit      <= any;
      out_win      <= pwin;
      out_kind_err <= !kind_known(pact[3:0]);
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  AST_ACCEPT_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid); // R9

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_action)
      && $stable(out_win)); // R9

  AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_addr[GRAN_BITS-1:0] == $past(in_addr[GRAN_BITS-1:0])); // R4

  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (hit_vec == '0) |=> !out_hit && (out_addr == $past(in_addr))); // R5

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6

endmodule

// File: tb/obwin_xlate_tb.sv
module obwin_xlate_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [63:0] in_addr, out_addr;
  logic [31:0] out_action, cfg_wdata, cfg_rdata;
  logic        out_hit, out_kind_err, cfg_we;
  logic [2:0]  out_win;
  logic [15:0] cfg_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obwin_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_action(out_action),
    .out_hit(out_hit), .out_win(out_win), .out_kind_err(out_kind_err), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [63:0] mm [8];
  logic [63:0] mr [8];
  logic [63:0] mk [8];
  logic [31:0] ma [8];
  logic [31:0] md;
  logic        mv, m_hit, m_kerr;
  logic [63:0] m_addr;
  logic [31:0] m_act;
  logic [2:0]  m_win;

  function automatic int unsigned m_read(input logic [15:0] a);
    int n, o;
    if (a < 16'h4C00 || a >= 16'h4D00) return 0;
    n = (int'(a) - 'h4C00) / 32;
    o = (int'(a) - 'h4C00) % 32;
    case (o)
      0:  return mm[n][31:0];
      4:  return mm[n][63:32];
      8:  return mr[n][31:0];
      12: return mr[n][63:32];
      16: return mk[n][31:0];
      20: return mk[n][63:32];
      24: return ma[n];
      28: return (n == 7) ? md : 0;
      default: return 0;
    endcase
  endfunction

  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        mm[i] = '0; mr[i] = '0; mk[i] = '0; ma[i] = '0;
      end
      md = '0; mv = 1'b0; m_hit = 1'b0; m_kerr = 1'b0;
      m_addr = '0; m_act = '0; m_win = '0;
    end else begin
      // translation uses the register state from before this edge
      if (in_valid && (!mv || out_ready)) begin
        m_hit = 1'b0; m_win = '0; m_addr = in_addr; m_act = md;
        for (int i = 0; i < 8; i++) begin
          logic [63:0] em;
          em = mk[i] & 64'hFFFF_FFFF_FFFF_0000;
          if (!m_hit && mm[i][0] && ((in_addr & em) == (mm[i] & em))) begin
            m_hit = 1'b1; m_win = 3'(i);
            m_addr = (mr[i] & em) | (in_addr & ~em);
            m_act = ma[i];
          end
        end
        m_kerr = !(m_act[3:0] inside {4'h0, 4'h4, 4'h8, 4'h9, 4'hC});
        mv = 1'b1;
      end else if (out_ready) begin
        mv = 1'b0;
      end
      if (cfg_we && cfg_addr >= 16'h4C00 && cfg_addr < 16'h4D00) begin
        int n, o;
        n = (int'(cfg_addr) - 'h4C00) / 32;
        o = (int'(cfg_addr) - 'h4C00) % 32;
        case (o)
          0:  mm[n][31:0]  = cfg_wdata;
          4:  mm[n][63:32] = cfg_wdata;
          8:  mr[n][31:0]  = cfg_wdata;
          12: mr[n][63:32] = cfg_wdata;
          16: mk[n][31:0]  = cfg_wdata;
          20: mk[n][63:32] = cfg_wdata;
          24: ma[n]        = cfg_wdata;
          28: if (n == 7) md = cfg_wdata;
          default: ;
        endcase
      end
      chk("R9 model in_ready", {63'd0, in_ready}, {63'd0, (!mv || out_ready)});
      chk("R9 model out_valid", {63'd0, out_valid}, {63'd0, mv});
      if (mv) begin
        chk("R4 model out_addr", out_addr, m_addr);
        chk("R5 model out_action", {32'd0, out_action}, {32'd0, m_act});
        chk("R3 model out_hit", {63'd0, out_hit}, {63'd0, m_hit});
        chk("R6 model out_win", {61'd0, out_win}, {61'd0, m_win});
        chk("R8 model out_kind_err", {63'd0, out_kind_err}, {63'd0, m_kerr});
      end
      chk("R2 model cfg_rdata", {32'd0, cfg_rdata}, {32'd0, m_read(cfg_addr)});
    end
  end

  // ---------------- directed stimulus ----------------
  function automatic logic [15:0] wa(input int n, input int off);
    return 16'(32'h4C00 + 32 * n + off);
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setwin(input int n, input logic [63:0] m, input logic [63:0] r,
                        input logic [63:0] k, input logic [31:0] act);
    wr(wa(n, 'h00), m[31:0]);  wr(wa(n, 'h04), m[63:32]);
    wr(wa(n, 'h08), r[31:0]);  wr(wa(n, 'h0C), r[63:32]);
    wr(wa(n, 'h10), k[31:0]);  wr(wa(n, 'h14), k[63:32]);
    wr(wa(n, 'h18), act);
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
    cfg_addr = a;
    #1;
    chk(tag, {32'd0, cfg_rdata}, {32'd0, exp});
  endtask

  task automatic xl(input logic [63:0] a, input logic ehit, input logic [2:0] ewin,
                    input logic [63:0] eaddr, input string tag);
    bit acc;
    in_valid = 1'b1; in_addr = a;
    do begin
      #1 acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
    chk({tag, " out_valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " out_hit"}, {63'd0, out_hit}, {63'd0, ehit});
    chk({tag, " out_win"}, {61'd0, out_win}, {61'd0, ewin});
    chk({tag, " out_addr"}, out_addr, eaddr);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; out_ready = 1'b1;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid at reset", {63'd0, out_valid}, 64'd0);
    chk("R1 in_ready at reset", {63'd0, in_ready}, 64'd1);
    rd_chk(16'h4CFC, 32'h0, "R1 default action");
    rd_chk(wa(3, 'h00), 32'h0, "R1 match word");
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4 basic window
    setwin(2, 64'h0000_0000_E800_0001, 64'h0000_0001_0000_0000,
           64'hFFFF_FFFF_FF00_0000, 32'h0000_0004);
    rd_chk(wa(2, 'h00), 32'hE800_0001, "R2 match lo");
    rd_chk(wa(2, 'h0C), 32'h0000_0001, "R2 remap hi");
    rd_chk(wa(2, 'h10), 32'hFF00_0000, "R2 mask lo");
    rd_chk(wa(2, 'h18), 32'h0000_0004, "R2 action");
    xl(64'hE812_3456, 1'b1, 3'd2, 64'h0000_0001_0012_3456, "R4 win2");
    chk("R8 action word", {32'd0, out_action}, 64'h4);
    chk("R8 io kind legal", {63'd0, out_kind_err}, 64'd0);

    // R5 miss, first with zero default then with attributes
    xl(64'h1234_5678, 1'b0, 3'd0, 64'h1234_5678, "R5 miss");
    chk("R5 default action zero", {32'd0, out_action}, 64'h0);
    wr(16'h4CFC, 32'h0000_08C0);
    rd_chk(16'h4CFC, 32'h0000_08C0, "R2 default readback");
    xl(64'h0000_00AB_0000_0010, 1'b0, 3'd0, 64'h0000_00AB_0000_0010, "R5 miss2");
    chk("R5 default action", {32'd0, out_action}, 64'h8C0);

    // R6 overlap: window 5 covers window 2's range
    setwin(5, 64'h0000_0000_E000_0001, 64'h0000_0002_0000_0000,
           64'hFFFF_FFFF_F000_0000, 32'h0000_0009);
    xl(64'hE812_3456, 1'b1, 3'd2, 64'h0000_0001_0012_3456, "R6 lowest wins");
    xl(64'hE000_1000, 1'b1, 3'd5, 64'h0000_0002_0000_1000, "R6 only win5");
    chk("R8 cfg1 action", {32'd0, out_action}, 64'h9);

    // R3/R4 granule: mask low 16 bits ignored
    setwin(0, 64'h0000_0000_4000_0001, 64'h0000_0003_1234_FFFF,
           64'hFFFF_FFFF_FFFF_FFFF, 32'h0);
    xl(64'h4000_ABCD, 1'b1, 3'd0, 64'h0000_0003_1234_ABCD, "R3 granule hit");
    xl(64'h4001_0000, 1'b0, 3'd0, 64'h4001_0000, "R3 bit16 miss");

    // R3 enable clear never hits
    setwin(3, 64'h0000_0000_5000_0000, 64'h0, 64'hFFFF_FFFF_FFFF_0000, 32'h4);
    xl(64'h5000_0000, 1'b0, 3'd0, 64'h5000_0000, "R3 disabled");
    chk("R3 disabled uses default", {32'd0, out_action}, 64'h8C0);

    // R7 zeroing window 2 hands the range to window 5
    setwin(2, 64'h0, 64'h0, 64'h0, 32'h0);
    rd_chk(wa(2, 'h00), 32'h0, "R7 match cleared");
    xl(64'hE812_3456, 1'b1, 3'd5, 64'h0000_0002_0812_3456, "R7 zeroed window");

    // R8 unknown type code
    setwin(6, 64'h0000_0100_0000_0001, 64'h0000_0200_0000_0000,
           64'hFFFF_FFFF_FFFF_0000, 32'h0000_0F83);
    xl(64'h0000_0100_0000_1234, 1'b1, 3'd6, 64'h0000_0200_0000_1234, "R8 win6");
    chk("R8 bad kind flagged", {63'd0, out_kind_err}, 64'd1);
    chk("R8 attributes passed", {32'd0, out_action}, 64'hF83);
    wr(wa(6, 'h18), 32'h0000_000C);
    xl(64'h0000_0100_0000_1234, 1'b1, 3'd6, 64'h0000_0200_0000_1234, "R8 msg");
    chk("R8 msg kind legal", {63'd0, out_kind_err}, 64'd0);

    // R2 reserved and out-of-range addresses
    wr(16'h4C1C, 32'hFFFF_FFFF);
    rd_chk(16'h4C1C, 32'h0, "R2 reserved slot");
    wr(16'h4BFC, 32'hFFFF_FFFF);
    rd_chk(16'h4BFC, 32'h0, "R2 below base");
    wr(16'h4D00, 32'hFFFF_FFFF);
    rd_chk(16'h4D00, 32'h0, "R2 above span");
    rd_chk(wa(0, 'h18), 32'h0, "R2 neighbour untouched");
    rd_chk(16'h4CFC, 32'h0000_08C0, "R2 default untouched");

    // R9 back-pressure
    out_ready = 1'b0;
    xl(64'h1234, 1'b0, 3'd0, 64'h1234, "R9 first");
    in_valid = 1'b1; in_addr = 64'h5678;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      chk("R9 stalled in_ready", {63'd0, in_ready}, 64'd0);
      chk("R9 stalled out_addr", out_addr, 64'h1234);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second out_addr", out_addr, 64'h5678);
    @(negedge clk);
    chk("R9 drained", {63'd0, out_valid}, 64'd0);

    // R10 write and accept on the same edge
    setwin(4, 64'h0000_0000_9000_0000, 64'h0000_0000_A000_0000,
           64'hFFFF_FFFF_FFFF_0000, 32'h0);
    cfg_we = 1'b1; cfg_addr = wa(4, 'h00); cfg_wdata = 32'h9000_0001;
    in_valid = 1'b1; in_addr = 64'h9000_0042;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R10 old config used", {63'd0, out_hit}, 64'd0);
    chk("R10 old config addr", out_addr, 64'h9000_0042);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 new config hit", {63'd0, out_hit}, 64'd1);
    chk("R10 new config addr", out_addr, 64'hA000_0042);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule